// File: doc/BRIEF.md
# ATM Receive Cell Screen and Router

This block sits after a cell delineation stage and receives one 57-octet slot at a time, one octet per clock. Each slot carries 4 overhead octets (indices 0..3), the 4-octet cell header (indices 4..7), the HEC octet (index 8) and 48 payload octets (indices 9..56). The block gathers the header and compares it against four programmable match words, each with its own mask. It sends the slot to the output port of the matching word. Slots whose header marks them as idle are dropped, and so are slots that match no enabled word.

The octets pass through a short lookahead delay line, so the header decision is known before the first octet of the slot leaves. The block can emit the whole slot, the 53-octet cell, the cell with the HEC octet removed, or only the payload. A per-octet flag reports whether any enabled check (header HEC, octet parity) has failed for the cell so far. Four saturating counters record events and errors and are cleared when read. A counter that overflows latches a bit in an interrupt source word.

Top module: `atm_rx_screen`

## Requirements
- R1: `cfg_fmt` selects which slot indices are emitted: 0 gives all 57 (0..56), 1 gives 53 (4..56), 2 gives 52 (4..7 and 9..56), 3 gives 48 (9..56). Octets leave in index order with their data unchanged.
- R2: While `cfg_utopia` is 1, indices 4..56 are emitted whatever `cfg_fmt` holds.
- R3: Filter i matches when `((hdr ^ flt_val[32i+31:32i]) & flt_mask[32i+31:32i]) == 0` and `flt_en[i]` is 1. The header is index 4 in bits 31:24 down to index 7 in bits 7:0. The slot goes out with `out_port_valid` one-hot at bit i, and no other bit is set.
- R4: When several enabled filters match, the lowest-numbered one receives the slot.
- R5: A non-idle slot that matches no enabled filter is not emitted, and it increments counter 1 (unmatched).
- R6: A slot whose header has bits 27:4 all zero and bit 0 set is idle. It is never emitted, even when a filter matches, and it increments counter 0.
- R7: Slot index k presented at input cycle t0+k appears at the output in cycle t0+k+D. D is 10 when `cfg_deep` is 1 or the effective format is the full slot, and 6 otherwise.
- R8: `out_soc` is 1 only on the first emitted octet of a slot. `out_par` is the XOR of the 8 output data bits.
- R9: With `cfg_chk_en[0]` set, a HEC octet that differs from the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, header octets MSB first) XOR 0x55 drives `out_cell_ok` to 0 on every emitted octet of the slot and increments counter 2. With the bit clear, the HEC octet has no effect on `out_cell_ok` and no count is made.
- R10: An input octet fails parity when `in_par` differs from the XOR of `in_data`. With `cfg_chk_en[1]` set, `out_cell_ok` is 0 from the failing index to the end of its slot, and every failing octet increments counter 3. With the bit clear, parity has no effect.
- R11: `rd_data` shows counter `rd_addr` (0..3). A cycle with `rd_stb` set clears that counter. Counters stop at 2^CNT_W-1.
- R12: An event arriving at a counter that is already at its maximum sets interrupt-source bit `rd_addr`-index. Address 4 reads the source bits, and a read there clears them. `irq` is the OR of the source bits ANDed with `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input octet present; a slot's 57 octets are on consecutive cycles |
| in_soc | input | 1 | Marks slot index 0 |
| in_data | input | 8 | Input octet |
| in_par | input | 1 | Even parity bit of the input octet |
| cfg_fmt | input | 2 | Output format select |
| cfg_utopia | input | 1 | Forces the 53-octet format |
| cfg_deep | input | 1 | Selects the 10-octet lookahead |
| cfg_chk_en | input | 2 | Bit 0 HEC check, bit 1 parity check |
| flt_en | input | N_PORT | Filter enables |
| flt_val | input | 32*N_PORT | Filter match words |
| flt_mask | input | 32*N_PORT | Filter masks, 1 = compare |
| rd_stb | input | 1 | Read strobe (clear on read) |
| rd_addr | input | 3 | 0..3 counters, 4 interrupt source |
| rd_data | output | CNT_W | Read data |
| irq_en | input | 4 | Interrupt enables per counter |
| irq | output | 1 | Interrupt request |
| out_port_valid | output | N_PORT | One-hot port strobe per emitted octet |
| out_data | output | 8 | Emitted octet |
| out_soc | output | 1 | First emitted octet of the slot |
| out_par | output | 1 | Even parity of `out_data` |
| out_cell_ok | output | 1 | No enabled check has failed so far |

## Verification
The assertions watch several properties on every cycle. The port strobe is at most one-hot. Start and cell-ok appear only with a strobe. Cell-ok, once low, does not recover on the next octet of a cell. Output indices rise by one. A saturated counter holds its value, a source bit stays set until read, and the chosen filter really is the lowest matching one. Only the bench scenarios can show the exact output cycle for each lookahead depth and format, the dropping of idle and unmatched slots, the HEC and parity effects, and the counter values and interrupt behaviour on readback.

// File: rtl/atm_rx_pkg.sv
// Shared definitions for the receive screen: slot layout, output formats,
// the delay-line entry type and small helper functions.
package atm_rx_pkg;

    localparam int SLOT_LEN   = 57;
    localparam int HDR_FIRST  = 4;
    localparam int HDR_LAST   = 7;
    localparam int HEC_POS    = 8;
    localparam int PAY_FIRST  = 9;
    localparam int IDX_W      = $clog2(SLOT_LEN);
    localparam int HDR_W      = 32;
    localparam int N_CNT      = 4;
    localparam int RD_AW      = $clog2(N_CNT + 1);
    localparam logic [7:0] HEC_COSET = 8'h55;

    typedef enum logic [1:0] {
        FMT_SLOT    = 2'd0,
        FMT_CELL    = 2'd1,
        FMT_NOHEC   = 2'd2,
        FMT_PAYLOAD = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
        logic             perr;
    } octet_t;

    // One octet of CRC-8 with polynomial x^8+x^2+x+1, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        logic       fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    // True when slot index idx is part of the selected output format.
    function automatic logic fmt_keeps(input fmt_e f, input logic [IDX_W-1:0] idx);
        case (f)
            FMT_SLOT:  return 1'b1;
            FMT_CELL:  return idx >= IDX_W'(HDR_FIRST);
            FMT_NOHEC: return (idx >= IDX_W'(HDR_FIRST)) && (idx != IDX_W'(HEC_POS));
            default:   return idx >= IDX_W'(PAY_FIRST);
        endcase
    endfunction

    // First index the selected format emits.
    function automatic logic [IDX_W-1:0] fmt_first(input fmt_e f);
        case (f)
            FMT_SLOT:    return '0;
            FMT_PAYLOAD: return IDX_W'(PAY_FIRST);
            default:     return IDX_W'(HDR_FIRST);
        endcase
    endfunction

endpackage

// File: rtl/atm_hdr_filter.sv
// Header screen: compares the assembled header with N_FILT masked match
// words and returns the lowest-numbered enabled hit. It also flags idle
// headers (bits 27:4 zero, bit 0 set). Purely combinational; assumes the
// caller samples the outputs only when the header is complete.
module atm_hdr_filter #(
    parameter int N_FILT = 4,
    parameter int HW     = 32,
    localparam int PW    = (N_FILT > 1) ? $clog2(N_FILT) : 1
) (
    input  logic [HW-1:0]        hdr,
    input  logic [N_FILT-1:0]    flt_en,
    input  logic [N_FILT*HW-1:0] flt_val,
    input  logic [N_FILT*HW-1:0] flt_mask,
    output logic                 hit,
    output logic [PW-1:0]        port,
    output logic                 idle
);

    logic [N_FILT-1:0] match;

    // One masked comparator per filter.
    for (genvar g = 0; g < N_FILT; g++) begin : g_cmp
        assign match[g] = flt_en[g] &&
            (((hdr ^ flt_val[g*HW +: HW]) & flt_mask[g*HW +: HW]) == '0);
    end

    // Priority pick: scanning down leaves the lowest match in place.
    always_comb begin
        hit  = 1'b0;
        port = '0;
        for (int i = N_FILT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                port = PW'(i);
            end
        end
    end

    // Idle header pattern: VPI/VCI zero with CLP set.
    assign idle = (hdr[27:4] == '0) && hdr[0];

    // R4 check: the chosen port matches and no lower one does.
    always_comb begin
        if (hit) begin
            a_r4_lowest_wins: assert (match[port] &&
                ((match & ((N_FILT'(1) << port) - N_FILT'(1))) == '0))
                else $error("lowest-match priority broken");
        end
    end

endmodule

// File: rtl/atm_octet_delay.sv
// Header lookahead line: every clock the input entry moves one stage on.
// The output taps stage DEPTH_LONG-1 or DEPTH_SHORT-1, so an entry leaves
// exactly D cycles after it entered. Assumes the depth select is static
// while slots are in flight.
module atm_octet_delay
    import atm_rx_pkg::*;
#(
    parameter int DEPTH_SHORT = 6,
    parameter int DEPTH_LONG  = 10
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   deep,
    input  octet_t din,
    output octet_t dout
);

    octet_t stage [DEPTH_LONG];

    // Shift register advancing every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_LONG; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH_LONG; i++) stage[i] <= stage[i-1];
        end
    end

    // Output tap selection.
    assign dout = deep ? stage[DEPTH_LONG-1] : stage[DEPTH_SHORT-1];

    // R7: consecutive leaving octets of a slot keep their index order.
    a_r7_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        (dout.vld && $past(dout.vld) && dout.idx != '0)
        |-> (dout.idx == $past(dout.idx) + IDX_W'(1)))
        else $error("delay line reordered octets");

endmodule

// File: rtl/atm_evt_counters.sv
// Counter bank: N_CNT saturating event counters, cleared on read, and an
// interrupt source word with one bit per counter. A bit is set when an
// event meets a full counter and is cleared by reading address N_CNT.
// Assumes CNT_W >= N_CNT so the source word fits the read bus.
module atm_evt_counters
    import atm_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] ev,
    input  logic             rd_stb,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [N_CNT-1:0] irq_en,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [N_CNT];
    logic [N_CNT-1:0] src;
    logic [N_CNT-1:0] ovf;
    logic [N_CNT-1:0] rd_hit;
    logic             rd_src;

    assign rd_src = rd_stb && (rd_addr == RD_AW'(N_CNT));

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        assign rd_hit[g] = rd_stb && (rd_addr == RD_AW'(g));
        assign ovf[g]    = ev[g] && (cnt[g] == CNT_MAX) && !rd_hit[g];

        // Count, saturate, and clear on read (an event in the read cycle is kept).
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt[g] <= '0;
            else if (rd_hit[g])  cnt[g] <= ev[g] ? CNT_W'(1) : '0;
            else if (ev[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + CNT_W'(1);
        end

        a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CNT_MAX && !rd_hit[g]) |=> (cnt[g] == CNT_MAX))
            else $error("counter left saturation");

        a_r12_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (src[g] && !rd_src) |=> src[g])
            else $error("interrupt source bit lost");
    end

    // Interrupt source: overflow sets, read clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) src <= '0;
        else        src <= (rd_src ? '0 : src) | ovf;
    end

    // Read multiplexer.
    always_comb begin
        rd_data = CNT_W'(src);
        for (int i = 0; i < N_CNT; i++) begin
            if (rd_addr == RD_AW'(i)) rd_data = cnt[i];
        end
    end

    assign irq = |(src & irq_en);

endmodule

// File: rtl/atm_rx_screen.sv
// Top of the receive screen. It indexes the incoming slot, assembles the
// header and HEC, runs the filter, and records the decision for the slot.
// It delays the octets through the lookahead line and emits the selected
// format on the chosen port with a cell-ok flag.
// Assumes the 57 octets of a slot arrive on consecutive cycles, in_soc marks
// index 0, and configuration is static while slots are in flight.
module atm_rx_screen
    import atm_rx_pkg::*;
#(
    parameter int N_PORT      = 4,
    parameter int CNT_W       = 8,
    parameter int DEPTH_SHORT = 6,
    parameter int DEPTH_LONG  = 10,
    localparam int PW         = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_soc,
    input  logic [7:0]             in_data,
    input  logic                   in_par,
    input  logic [1:0]             cfg_fmt,
    input  logic                   cfg_utopia,
    input  logic                   cfg_deep,
    input  logic [1:0]             cfg_chk_en,
    input  logic [N_PORT-1:0]      flt_en,
    input  logic [N_PORT*HDR_W-1:0] flt_val,
    input  logic [N_PORT*HDR_W-1:0] flt_mask,
    input  logic                   rd_stb,
    input  logic [RD_AW-1:0]       rd_addr,
    output logic [CNT_W-1:0]       rd_data,
    input  logic [N_CNT-1:0]       irq_en,
    output logic                   irq,
    output logic [N_PORT-1:0]      out_port_valid,
    output logic [7:0]             out_data,
    output logic                   out_soc,
    output logic                   out_par,
    output logic                   out_cell_ok
);

    localparam int EV_IDLE = 0;
    localparam int EV_MISS = 1;
    localparam int EV_HEC  = 2;
    localparam int EV_PAR  = 3;

    // ---------------- input side ----------------
    logic [IDX_W-1:0] in_cnt, cur_idx;
    logic [23:0]      hdr_sr;
    logic [HDR_W-1:0] hdr_full;
    logic [7:0]       crc;
    logic             at_hdr_end, at_hec, hec_bad, in_perr;
    logic             f_hit, f_idle;
    logic [PW-1:0]    f_port;
    logic [N_CNT-1:0] ev;
    fmt_e             fmt_eff;
    logic             deep_eff;

    assign cur_idx    = in_soc ? '0 : in_cnt;
    assign at_hdr_end = in_valid && (cur_idx == IDX_W'(HDR_LAST));
    assign at_hec     = in_valid && (cur_idx == IDX_W'(HEC_POS));
    assign hdr_full   = {hdr_sr, in_data};
    assign hec_bad    = (in_data != (crc ^ HEC_COSET));
    assign in_perr    = in_par ^ (^in_data);
    assign fmt_eff    = cfg_utopia ? FMT_CELL : fmt_e'(cfg_fmt);
    assign deep_eff   = cfg_deep || (fmt_eff == FMT_SLOT);

    // Slot index counter for the next input octet.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_cnt <= '0;
        else if (in_valid) in_cnt <= cur_idx + IDX_W'(1);
    end

    // Header octet collector (first three header octets; the fourth is live).
    always_ff @(posedge clk) begin
        if (!rst_n) hdr_sr <= '0;
        else if (in_valid && cur_idx >= IDX_W'(HDR_FIRST) && cur_idx < IDX_W'(HDR_LAST))
            hdr_sr <= {hdr_sr[15:0], in_data};
    end

    // Running CRC-8 over the four header octets.
    always_ff @(posedge clk) begin
        if (!rst_n) crc <= '0;
        else if (in_valid && cur_idx == IDX_W'(HDR_FIRST)) crc <= crc8_step(8'h00, in_data);
        else if (in_valid && cur_idx > IDX_W'(HDR_FIRST) && cur_idx <= IDX_W'(HDR_LAST))
            crc <= crc8_step(crc, in_data);
    end

    atm_hdr_filter #(.N_FILT(N_PORT), .HW(HDR_W)) u_filter (
        .hdr      (hdr_full),
        .flt_en   (flt_en),
        .flt_val  (flt_val),
        .flt_mask (flt_mask),
        .hit      (f_hit),
        .port     (f_port),
        .idle     (f_idle)
    );

    // ---------------- slot decision ----------------
    logic          pend_hit, held_hit, pend_hec, held_hec;
    logic [PW-1:0] pend_port, held_port;

    // Decision of the newest slot: route at the last header octet, HEC one later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_hit  <= 1'b0;
            pend_port <= '0;
            pend_hec  <= 1'b0;
        end else begin
            if (at_hdr_end) begin
                pend_hit  <= f_hit && !f_idle;
                pend_port <= f_port;
            end
            if (at_hec) pend_hec <= hec_bad;
        end
    end

    // Event strobes toward the counter bank.
    always_comb begin
        ev          = '0;
        ev[EV_IDLE] = at_hdr_end && f_idle;
        ev[EV_MISS] = at_hdr_end && !f_idle && !f_hit;
        ev[EV_HEC]  = at_hec && hec_bad && cfg_chk_en[0];
        ev[EV_PAR]  = in_valid && in_perr && cfg_chk_en[1];
    end

    // ---------------- lookahead line ----------------
    octet_t line_in, head;

    assign line_in = '{vld: in_valid, idx: cur_idx, data: in_data, perr: in_perr};

    atm_octet_delay #(.DEPTH_SHORT(DEPTH_SHORT), .DEPTH_LONG(DEPTH_LONG)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .deep  (deep_eff),
        .din   (line_in),
        .dout  (head)
    );

    // ---------------- output side ----------------
    logic          use_pend, dec_hit, dec_hec, emit, perr_sofar, perr_sticky;
    logic [PW-1:0] dec_port;

    assign use_pend = head.idx <= IDX_W'(HEC_POS);
    assign dec_hit  = use_pend ? pend_hit  : held_hit;
    assign dec_port = use_pend ? pend_port : held_port;
    assign dec_hec  = use_pend ? pend_hec  : held_hec;

    // Hold the decision once the leaving slot passes its HEC position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hit  <= 1'b0;
            held_port <= '0;
            held_hec  <= 1'b0;
        end else if (head.vld && head.idx == IDX_W'(HEC_POS)) begin
            held_hit  <= pend_hit;
            held_port <= pend_port;
            held_hec  <= pend_hec;
        end
    end

    assign perr_sofar = ((head.idx == '0) ? 1'b0 : perr_sticky) | head.perr;

    // Parity failure seen so far in the leaving slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        perr_sticky <= 1'b0;
        else if (head.vld) perr_sticky <= perr_sofar;
    end

    assign emit = head.vld && dec_hit && fmt_keeps(fmt_eff, head.idx);

    // Output drive, all from registered state.
    always_comb begin
        out_port_valid = '0;
        out_data       = '0;
        out_soc        = 1'b0;
        out_cell_ok    = 1'b0;
        if (emit) begin
            out_port_valid[dec_port] = 1'b1;
            out_data    = head.data;
            out_soc     = head.idx == fmt_first(fmt_eff);
            out_cell_ok = !(cfg_chk_en[0] && dec_hec) && !(cfg_chk_en[1] && perr_sofar);
        end
    end
    assign out_par = ^out_data;

    atm_evt_counters #(.CNT_W(CNT_W)) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_en  (irq_en),
        .irq     (irq)
    );

    // ---------------- assertions ----------------
    a_r3_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_port_valid))
        else $error("more than one port strobe");

    a_r8_soc_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> (|out_port_valid))
        else $error("start flag without an octet");

    a_r9_ok_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_cell_ok |-> (|out_port_valid))
        else $error("cell-ok without an octet");

    a_r10_ok_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_port_valid) && !out_cell_ok) |=> (!(|out_port_valid) || out_soc || !out_cell_ok))
        else $error("cell-ok recovered inside a cell");

    a_r2_cell_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_utopia && (|out_port_valid)) |-> (head.idx >= IDX_W'(HDR_FIRST)))
        else $error("overhead octet emitted in 53-octet mode");

endmodule

// File: tb/atm_rx_screen_bench.sv
module atm_rx_screen_bench;
    localparam int NP = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_soc = 0, in_par = 0;
    logic [7:0] in_data = 0;
    logic [1:0] cfg_fmt = 1, cfg_chk_en = 0;
    logic cfg_utopia = 0, cfg_deep = 0;
    logic [NP-1:0] flt_en = 0;
    logic [NP*32-1:0] flt_val = 0, flt_mask = 0;
    logic rd_stb = 0;
    logic [2:0] rd_addr = 0;
    logic [CW-1:0] rd_data;
    logic [3:0] irq_en = 0;
    logic irq;
    logic [NP-1:0] out_port_valid;
    logic [7:0] out_data;
    logic out_soc, out_par, out_cell_ok;

    atm_rx_screen u_atm_rx_screen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .in_par(in_par), .cfg_fmt(cfg_fmt),
        .cfg_utopia(cfg_utopia), .cfg_deep(cfg_deep), .cfg_chk_en(cfg_chk_en),
        .flt_en(flt_en), .flt_val(flt_val), .flt_mask(flt_mask),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq), .out_port_valid(out_port_valid),
        .out_data(out_data), .out_soc(out_soc), .out_par(out_par),
        .out_cell_ok(out_cell_ok));

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, t0 = 0;
    bit done = 0;
    logic [31:0] cur_hdr;
    bit cur_hec_bad;
    logic [7:0] seed = 8'h11;

    int cap_n = 0;
    logic [7:0] cap_data [64];
    logic [NP-1:0] cap_port [64];
    logic cap_soc [64], cap_par [64], cap_ok [64];
    int cap_cyc [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (|out_port_valid && cap_n < 64) begin
            cap_data[cap_n] = out_data;  cap_port[cap_n] = out_port_valid;
            cap_soc[cap_n] = out_soc;    cap_par[cap_n] = out_par;
            cap_ok[cap_n] = out_cell_ok; cap_cyc[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string msg, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, msg, act, exp);
        end
    endtask

    function automatic logic [7:0] hec_of(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = c[7] ^ h[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c ^ 8'h55;
    endfunction

    function automatic logic [7:0] slot_byte(input int k);
        if (k < 4) return 8'hA0 + 8'(k);
        if (k < 8) return cur_hdr[8*(7-k) +: 8];
        if (k == 8) return hec_of(cur_hdr) ^ (cur_hec_bad ? 8'h01 : 8'h00);
        return seed + 8'(k * 3);
    endfunction

    // par_bad: -1 none, 99 every octet, else one index.
    task automatic send(input logic [31:0] h, input bit hbad, input int par_bad);
        cur_hdr = h; cur_hec_bad = hbad; cap_n = 0; seed = seed + 8'h1D;
        for (int k = 0; k < 57; k++) begin
            @(posedge clk); #2;
            if (k == 0) t0 = cyc;
            in_valid = 1; in_soc = (k == 0); in_data = slot_byte(k);
            in_par = (^slot_byte(k)) ^ ((par_bad == 99 || par_bad == k) ? 1'b1 : 1'b0);
        end
        @(posedge clk); #2;
        in_valid = 0; in_soc = 0;
        repeat (16) @(posedge clk);
        #2;
    endtask

    // eport < 0: nothing emitted. bad_from: first index with cell-ok low.
    task automatic check_slot(input int eport, input int efmt, input int dep, input int bad_from, input string req);
        int first, n;
        if (eport < 0) begin
            check(cap_n == 0, req, "octets emitted for dropped slot", cap_n, 0);
            return;
        end
        first = (efmt == 0) ? 0 : (efmt == 3) ? 9 : 4;
        n = 0;
        for (int k = first; k < 57; k++) begin
            if (efmt == 2 && k == 8) continue;
            if (n < cap_n) begin
                logic [7:0] ed = slot_byte(k);
                check(cap_data[n] == ed, req, $sformatf("data idx %0d", k), cap_data[n], ed);
                check(cap_cyc[n] == t0 + k + dep, req, $sformatf("cycle idx %0d", k), cap_cyc[n], t0 + k + dep);
                check(cap_port[n] == NP'(1 << eport), req, "port strobe", cap_port[n], 1 << eport);
                check(cap_soc[n] == (n == 0), "R8", $sformatf("soc idx %0d", k), cap_soc[n], n == 0);
                check(cap_par[n] == ^ed, "R8", "parity", cap_par[n], ^ed);
                check(cap_ok[n] == (k < bad_from), req, $sformatf("cell_ok idx %0d", k), cap_ok[n], k < bad_from);
            end
            n++;
        end
        check(cap_n == n, req, "octet count", cap_n, n);
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] v);
        @(posedge clk); #2;
        rd_stb = 1; rd_addr = a;
        @(negedge clk); v = rd_data;
        @(posedge clk); #2;
        rd_stb = 0;
    endtask

    task automatic set_flt(input int i, input logic [31:0] v, input logic [31:0] m);
        flt_val[32*i +: 32] = v; flt_mask[32*i +: 32] = m; flt_en[i] = 1;
    endtask

    task automatic t_reset;
        logic [CW-1:0] v;
        check(out_port_valid == 0 && out_soc == 0 && out_cell_ok == 0, "R3", "outputs after reset",
              {out_port_valid, out_soc, out_cell_ok}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check(v == 0, "R11", $sformatf("reset read %0d", a), v, 0);
        end
        check(irq == 0, "R12", "irq after reset", irq, 0);
    endtask

    task automatic t_formats;
        set_flt(0, 32'h0123_4560, 32'hFFFF_FFFF);
        cfg_fmt = 1; cfg_deep = 0; send(32'h0123_4560, 0, -1); check_slot(0, 1, 6, 99, "R1");
        cfg_fmt = 3; cfg_deep = 1; send(32'h0123_4560, 0, -1); check_slot(0, 3, 10, 99, "R7");
        cfg_fmt = 0; cfg_deep = 0; send(32'h0123_4560, 0, -1); check_slot(0, 0, 10, 99, "R7");
        cfg_fmt = 2; cfg_deep = 0; send(32'h0123_4560, 0, -1); check_slot(0, 2, 6, 99, "R1");
    endtask

    task automatic t_utopia;
        cfg_utopia = 1; cfg_fmt = 3; cfg_deep = 0;
        send(32'h0123_4560, 0, -1); check_slot(0, 1, 6, 99, "R2");
        cfg_fmt = 0; send(32'h0123_4560, 0, -1); check_slot(0, 1, 6, 99, "R2");
        cfg_utopia = 0; cfg_fmt = 1;
    endtask

    task automatic t_priority;
        set_flt(1, 32'h0ABC_0000, 32'hFFFF_0000);
        set_flt(2, 32'h0ABC_DEF0, 32'hFFFF_FFFF);
        send(32'h0ABC_DEF0, 0, -1); check_slot(1, 1, 6, 99, "R4");
        flt_en[1] = 0;
        send(32'h0ABC_DEF0, 0, -1); check_slot(2, 1, 6, 99, "R3");
    endtask

    task automatic t_drop;
        logic [CW-1:0] v;
        flt_en = 4'b0001;
        send(32'h0777_0000, 0, -1); check_slot(-1, 1, 6, 99, "R5");
        rd(1, v); check(v == 1, "R5", "unmatched count", v, 1);
        set_flt(3, 32'h0, 32'h0);
        send(32'h0000_0001, 0, -1); check_slot(-1, 1, 6, 99, "R6");
        send(32'h5000_0001, 0, -1); check_slot(-1, 1, 6, 99, "R6");
        rd(0, v); check(v == 2, "R6", "idle count", v, 2);
        send(32'h0000_0010, 0, -1); check_slot(3, 1, 6, 99, "R3");
        flt_en = 4'b0001;
    endtask

    task automatic t_hec;
        logic [CW-1:0] v;
        cfg_chk_en = 2'b01;
        send(32'h0123_4560, 1, -1); check_slot(0, 1, 6, 0, "R9");
        send(32'h0123_4560, 0, -1); check_slot(0, 1, 6, 99, "R9");
        rd(2, v); check(v == 1, "R9", "hec count", v, 1);
        cfg_chk_en = 2'b00;
        send(32'h0123_4560, 1, -1); check_slot(0, 1, 6, 99, "R9");
        rd(2, v); check(v == 0, "R9", "hec count when off", v, 0);
    endtask

    task automatic t_parity;
        logic [CW-1:0] v;
        cfg_chk_en = 2'b10;
        send(32'h0123_4560, 0, 30); check_slot(0, 1, 6, 30, "R10");
        rd(3, v); check(v == 1, "R10", "parity count", v, 1);
        cfg_chk_en = 2'b00;
        send(32'h0123_4560, 0, 30); check_slot(0, 1, 6, 99, "R10");
        rd(3, v); check(v == 0, "R10", "parity count when off", v, 0);
    endtask

    task automatic t_saturate;
        logic [CW-1:0] v;
        cfg_chk_en = 2'b10; irq_en = 4'b1000;
        for (int s = 0; s < 5; s++) send(32'h0123_4560, 0, 99);
        check(irq == 1, "R12", "irq after overflow", irq, 1);
        rd(3, v); check(v == 8'hFF, "R11", "saturated count", v, 8'hFF);
        rd(3, v); check(v == 0, "R11", "cleared by read", v, 0);
        rd(4, v); check(v[3] == 1, "R12", "source bit", v, 8);
        rd(4, v); check(v == 0, "R12", "source cleared", v, 0);
        check(irq == 0, "R12", "irq after clear", irq, 0);
        cfg_chk_en = 2'b00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_utopia();
        t_priority();
        t_drop();
        t_hec();
        t_parity();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule